// File: doc/BRIEF.md
# SPI Byte Memory Slave

This block is the serial slave side of a byte-wide memory that is held as a register array inside the block. A host drives chip select, serial clock, serial data in and a pause line. The block samples all four lines into its own system clock domain, finds the clock edges there, and runs one command per chip-select frame. The first byte of a frame is the command. Memory commands take a two-byte address and then stream any number of data bytes. The address steps up by one after every byte and wraps from the top of the array back to zero.

Writes go straight into the array as each byte completes. There is no page buffer and the host never has to poll for a ready state. The write-enable latch and the block-protection decode belong to a separate protection unit. This block only sends that unit command pulses and the current write address. It writes a byte only when the unit reports the address writable, and it forwards the unit's status byte to the host on request. The array depth is set by the parameter `ADDR_W`, from 9 to 16 bits. A setting of 13 gives 8192 bytes; the default of 10 keeps elaboration small.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, `so_oe` is low and none of `set_wen`, `clr_wen`, `st_wr` or `frame_done` pulses until a frame has been sent.
- R2: SI is captured on rising SCK and SO moves on falling SCK, most significant bit first. A host with the clock idling low (mode 0) and one with it idling high (mode 3) both transfer correctly.
- R3: Command byte 0x06 gives a one-cycle `set_wen` pulse. Command 0x04 gives a one-cycle `clr_wen` pulse. After command 0x01, the next byte gives one `st_wr` pulse with that byte on `st_wdata`. Command 0x05 returns `st_byte` on SO.
- R4: Only the first byte of a frame is decoded as a command. Bytes that follow a complete 0x06, 0x04 or status-write sequence cause no further pulse.
- R5: A command byte other than 0x06, 0x04, 0x05, 0x01, 0x03 or 0x02 makes the block ignore the rest of the frame: no pulse, no write and no SO drive.
- R6: Command 0x03 (read) and command 0x02 (write) are each followed by a 16-bit address sent high byte first. Address bits at position `ADDR_W` and above are ignored.
- R7: Each data byte after the address uses the next address. After address 2^ADDR_W-1 the next address is 0.
- R8: A write data byte is stored when its eighth bit arrives, and only if `wp_ok` is high for the address on `wp_addr`. Any bits of a byte left incomplete when CS_n rises are discarded.
- R9: During read data, SI is ignored and SO carries the array byte. `so_oe` is high only while read data or the status byte is being shifted out.
- R10: While `hold_n` is low, SCK edges and CS_n changes are ignored and `so_oe` is low. When `hold_n` is released, the frame continues from the bit where it stopped. A change on `hold_n` takes effect only while SCK is low.
- R11: Each frame end (CS_n high) gives one `frame_done` pulse, so the protection unit can clear its write-enable latch after a write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Pause line, active low |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for `so` |
| wp_addr | output | ADDR_W | Address the next write byte targets |
| wp_ok | input | 1 | Protection unit: `wp_addr` may be written |
| st_byte | input | 8 | Status byte from the protection unit |
| set_wen | output | 1 | Pulse on command 0x06 |
| clr_wen | output | 1 | Pulse on command 0x04 |
| st_wr | output | 1 | Pulse carrying a status write |
| st_wdata | output | 8 | Status write byte |
| frame_done | output | 1 | Pulse at the end of each frame |

## Verification
Bursts are written and then read back in mode 0 and in mode 3, which separates edge choice and bit-order faults from address-counter faults. A burst that crosses the top address shows whether the counter wraps or stalls. A burst with a protection boundary inside it shows that the permit is checked per byte rather than once per frame. A high-bit-polluted address, a truncated final byte and a frame paused in the middle of a read byte each check one rule that the plain bursts cannot separate. Non-memory commands followed by trailing bytes, and an undefined command followed by valid-looking bytes, show that only the first byte of a frame is decoded.

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic [ADDR_W-1:0] wp_addr,
  input  logic              wp_ok,
  input  logic [7:0]        st_byte,
  output logic              set_wen,
  output logic              clr_wen,
  output logic              st_wr,
  output logic [7:0]        st_wdata,
  output logic              frame_done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  typedef enum logic [2:0] {
    S_CMD, S_ADR, S_WDAT, S_RDAT, S_SWR, S_SRD, S_SKIP
  } st_t;

  logic [1:0] cs_sy, sck_sy, si_sy, hold_sy;
  logic       sck_q, held, in_frame, rd_cmd, hi_done;
  logic [2:0] bitcnt;
  logic [6:0] rxsh;
  logic [7:0] txsh;
  logic [HI_W-1:0]   adr_hi;
  logic [ADDR_W-1:0] adr;
  st_t        st;
  logic [7:0] mem [DEPTH];

  wire s_cs = cs_sy[1];
  wire s_sck = sck_sy[1];
  wire s_si = si_sy[1];
  wire live = in_frame & ~held & ~s_cs;
  wire sck_rise = live & s_sck & ~sck_q;
  wire sck_fall = live & ~s_sck & sck_q;
  wire [7:0] byte_in = {rxsh, s_si};
  wire byte_done = sck_rise && bitcnt == 3'd7;
  wire [ADDR_W-1:0] adr_next = adr + 1'b1;
  wire [ADDR_W-1:0] adr_load = {adr_hi, byte_in};
  wire mem_we = byte_done && st == S_WDAT && wp_ok;
  wire shifting_out = st == S_RDAT || st == S_SRD;

  assign so = txsh[7];
  assign so_oe = in_frame & ~held & shifting_out;
  assign wp_addr = adr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= 2'b11; sck_sy <= 2'b00; si_sy <= 2'b00; hold_sy <= 2'b11;
    end else begin
      cs_sy <= {cs_sy[0], cs_n};
      sck_sy <= {sck_sy[0], sck};
      si_sy <= {si_sy[0], si};
      hold_sy <= {hold_sy[0], hold_n};
    end
  end

  always_ff @(posedge clk) if (mem_we) mem[adr] <= byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; held <= 1'b0; in_frame <= 1'b0; rd_cmd <= 1'b0;
      hi_done <= 1'b0; bitcnt <= '0; rxsh <= '0; txsh <= '0;
      adr_hi <= '0; adr <= '0; st <= S_CMD;
      set_wen <= 1'b0; clr_wen <= 1'b0; st_wr <= 1'b0;
      st_wdata <= '0; frame_done <= 1'b0;
    end else begin
      sck_q <= s_sck;
      set_wen <= 1'b0; clr_wen <= 1'b0; st_wr <= 1'b0; frame_done <= 1'b0;
      if (!s_sck) held <= ~hold_sy[1];
      if (!held) begin
        if (s_cs) begin
          frame_done <= in_frame;
          in_frame <= 1'b0;
          st <= S_CMD;
          bitcnt <= '0;
        end else if (!in_frame) begin
          in_frame <= 1'b1;
          st <= S_CMD;
          bitcnt <= '0;
          hi_done <= 1'b0;
        end else if (sck_rise) begin
          rxsh <= byte_in[6:0];
          bitcnt <= bitcnt + 3'd1;
          if (byte_done) begin
            case (st)
              S_CMD: begin
                case (byte_in)
                  8'h06: begin set_wen <= 1'b1; st <= S_SKIP; end
                  8'h04: begin clr_wen <= 1'b1; st <= S_SKIP; end
                  8'h05: begin txsh <= st_byte; st <= S_SRD; end
                  8'h01: st <= S_SWR;
                  8'h03: begin rd_cmd <= 1'b1; hi_done <= 1'b0; st <= S_ADR; end
                  8'h02: begin rd_cmd <= 1'b0; hi_done <= 1'b0; st <= S_ADR; end
                  default: st <= S_SKIP;
                endcase
              end
              S_ADR: begin
                if (!hi_done) begin
                  adr_hi <= byte_in[HI_W-1:0];
                  hi_done <= 1'b1;
                end else begin
                  adr <= adr_load;
                  if (rd_cmd) begin
                    txsh <= mem[adr_load];
                    st <= S_RDAT;
                  end else begin
                    st <= S_WDAT;
                  end
                end
              end
              S_WDAT: adr <= adr_next;
              S_RDAT: begin adr <= adr_next; txsh <= mem[adr_next]; end
              S_SWR: begin st_wr <= 1'b1; st_wdata <= byte_in; st <= S_SKIP; end
              S_SRD: txsh <= st_byte;
              default: st <= S_SKIP;
            endcase
          end
        end else if (sck_fall && bitcnt != 3'd0 && shifting_out) begin
          txsh <= {txsh[6:0], 1'b0};
        end
      end
    end
  end

  // R4: once past the command byte, the frame never decodes another command
  assert_one_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && st != S_CMD) |=> !(in_frame && st == S_CMD));

  // R7: every finished data byte steps the address by one, wrapping at the top
  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (st == S_WDAT || st == S_RDAT)) |=> (adr == ADDR_W'($past(adr) + 1'b1)));

  // R10: a paused frame keeps its bit position, address and state
  assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> ($stable(bitcnt) && $stable(adr) && $stable(st) && $stable(in_frame)));

  // R9: the output is driven only inside a frame
  assert_oe_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> in_frame);

  // R3: command pulses never coincide and each lasts one cycle
  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_wen, clr_wen, st_wr, frame_done}));

  assert_wen_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_wen |=> !set_wen);

  // R11: frame_done only follows chip select going high
  assert_done_on_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> s_cs);
endmodule

// File: tb/spi_mem_slave_tb.sv
`timescale 1ns/1ps
module spi_mem_slave_tb;
  localparam int AW = 10;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, hold_n = 1;
  logic so, so_oe, wp_ok, set_wen, clr_wen, st_wr, frame_done;
  logic [AW-1:0] wp_addr;
  logic [7:0] st_byte = 8'h00, st_wdata;
  int lim = 1 << AW;
  int n_chk = 0, n_fail = 0;
  int n_set = 0, n_clr = 0, n_stw = 0, n_fd = 0;
  logic [7:0] last_stw = 0;
  bit oe_seen = 0;

  always #2.5 clk = ~clk;
  assign wp_ok = int'(wp_addr) < lim;

  spi_mem_slave #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .wp_addr(wp_addr), .wp_ok(wp_ok), .st_byte(st_byte),
    .set_wen(set_wen), .clr_wen(clr_wen), .st_wr(st_wr), .st_wdata(st_wdata),
    .frame_done(frame_done));

  always @(posedge clk) if (rst_n) begin
    if (set_wen) n_set++;
    if (clr_wen) n_clr++;
    if (st_wr) begin n_stw++; last_stw = st_wdata; end
    if (frame_done) n_fd++;
    if (so_oe) oe_seen = 1;
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xbits(input [7:0] tx, input int nb, input int hold_at, output logic [7:0] rx);
    rx = 0;
    for (int i = 7; i > 7 - nb; i--) begin
      sck = 0; si = tx[i]; clks(4);
      if (i == hold_at) begin
        hold_n = 0; clks(4);
        check("R10 oe low in hold", so_oe, 0);
        for (int k = 0; k < 3; k++) begin sck = 1; si = ~si; clks(4); sck = 0; clks(4); end
        si = tx[i]; hold_n = 1; clks(4);
      end
      rx[i] = so;
      sck = 1; clks(4);
    end
  endtask

  task automatic xbyte(input [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, -1, rx);
  endtask

  task automatic fbegin(input bit m3);
    sck = m3; clks(2); cs_n = 0; clks(4);
  endtask

  task automatic fend(input bit m3);
    if (!m3) sck = 0;
    clks(4); cs_n = 1; clks(6);
  endtask

  task automatic cmd1(input [7:0] op, input bit m3);
    logic [7:0] r;
    fbegin(m3); xbyte(op, r); fend(m3);
  endtask

  task automatic do_write(input [15:0] a, input [7:0] d0, d1, d2, input int n, input bit m3);
    logic [7:0] r;
    cmd1(8'h06, m3);
    fbegin(m3);
    xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    if (n > 0) xbyte(d0, r);
    if (n > 1) xbyte(d1, r);
    if (n > 2) xbyte(d2, r);
    fend(m3);
  endtask

  task automatic do_read(input [15:0] a, input bit m3, input int hold_at,
                         output logic [7:0] r0, r1, r2);
    logic [7:0] r;
    fbegin(m3);
    xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    xbits(8'hFF, 8, hold_at, r0); xbyte(8'hFF, r1); xbyte(8'h00, r2);
    fend(m3);
  endtask

  task automatic t_reset;
    check("R1 so_oe after reset", so_oe, 0);
    check("R1 no pulses after reset", n_set + n_clr + n_stw + n_fd, 0);
  endtask

  task automatic t_wen;
    logic [7:0] r;
    cmd1(8'h06, 0);
    check("R3 set_wen pulse", n_set, 1);
    check("R11 frame_done count", n_fd, 1);
    cmd1(8'h04, 1);
    check("R3 clr_wen pulse", n_clr, 1);
    fbegin(0); xbyte(8'h06, r); xbyte(8'h04, r); xbyte(8'h06, r); fend(0);
    check("R4 trailing bytes after 0x06 set", n_set, 2);
    check("R4 trailing 0x04 ignored", n_clr, 1);
  endtask

  task automatic t_bad;
    logic [7:0] r;
    int s = n_set, c = n_clr, w = n_stw;
    oe_seen = 0;
    fbegin(0); xbyte(8'hA5, r); xbyte(8'h06, r); xbyte(8'h01, r); xbyte(8'h05, r); fend(0);
    check("R5 undefined command no pulses", n_set + n_clr + n_stw, s + c + w);
    check("R5 undefined command no drive", oe_seen, 0);
  endtask

  task automatic t_status;
    logic [7:0] r;
    fbegin(0); xbyte(8'h01, r); xbyte(8'h8C, r); xbyte(8'h33, r); fend(0);
    check("R3 status write pulse", n_stw, 1);
    check("R3 status write data", last_stw, 8'h8C);
    st_byte = 8'h4A;
    fbegin(0); xbyte(8'h05, r); xbyte(8'h00, r); fend(0);
    check("R3 status read mode0", r, 8'h4A);
    st_byte = 8'hB1;
    fbegin(1); xbyte(8'h05, r); xbyte(8'h00, r); fend(1);
    check("R2 status read mode3", r, 8'hB1);
  endtask

  task automatic t_burst;
    logic [7:0] a, b, c;
    do_write(16'h0010, 8'h11, 8'h22, 8'h33, 3, 0);
    do_read(16'h0010, 0, -1, a, b, c);
    check("R7 burst byte0 mode0", a, 8'h11);
    check("R7 burst byte1 mode0", b, 8'h22);
    check("R7 burst byte2 mode0", c, 8'h33);
    do_write(16'h0030, 8'hC5, 8'h3A, 8'h00, 2, 1);
    do_read(16'h0030, 1, -1, a, b, c);
    check("R2 mode3 write/read byte0", a, 8'hC5);
    check("R2 mode3 write/read byte1", b, 8'h3A);
    do_read(16'h0010, 0, -1, a, b, c);
    check("R9 SI ignored during read", a, 8'h11);
  endtask

  task automatic t_addr;
    logic [7:0] a, b, c;
    do_write(16'hFC12, 8'h6E, 8'h00, 8'h00, 1, 0);
    do_read(16'h0012, 0, -1, a, b, c);
    check("R6 upper address bits ignored", a, 8'h6E);
    do_write(16'h03FE, 8'hA1, 8'hA2, 8'hA3, 3, 0);
    do_read(16'h03FF, 0, -1, a, b, c);
    check("R7 top address", a, 8'hA2);
    check("R7 wrap to zero", b, 8'hA3);
    do_read(16'h0000, 0, -1, a, b, c);
    check("R7 wrap data at address 0", a, 8'hA3);
  endtask

  task automatic t_protect;
    logic [7:0] a, b, c, r;
    do_write(16'h0100, 8'h77, 8'h00, 8'h00, 1, 0);
    do_write(16'h0021, 8'h99, 8'h00, 8'h00, 1, 0);
    lim = 16'h0100;
    do_write(16'h00FF, 8'h5A, 8'h6B, 8'h00, 2, 0);
    lim = 1 << AW;
    do_read(16'h00FF, 0, -1, a, b, c);
    check("R8 permitted byte written", a, 8'h5A);
    check("R8 refused byte kept", b, 8'h77);
    cmd1(8'h06, 0);
    fbegin(0);
    xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h20, r); xbyte(8'hC3, r);
    xbits(8'h0F, 4, -1, r);
    fend(0);
    do_read(16'h0020, 0, -1, a, b, c);
    check("R8 full byte written", a, 8'hC3);
    check("R8 partial byte discarded", b, 8'h99);
  endtask

  task automatic t_hold;
    logic [7:0] a, b, c;
    do_read(16'h0010, 0, 4, a, b, c);
    check("R10 read resumes after hold", a, 8'h11);
    check("R10 next byte after hold", b, 8'h22);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    clks(5); rst_n = 1; clks(5);
    t_reset;
    t_wen;
    t_bad;
    t_status;
    t_burst;
    t_addr;
    t_protect;
    t_hold;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule